// File: doc/BRIEF.md
# CRT Framebuffer Scanout Engine

This block turns a linear framebuffer held in local memory into a stream of 24-bit RGB pixels, one per strobe. Software programs a framebuffer base, the horizontal and vertical totals and a control word through a small write/read register port, then sets the enable bit. The engine walks the frame from its top-left pixel, line after line, and fetches each pixel's memory word through a request/ready handshake. The pixel is then converted to RGB and presented with a one-cycle valid strobe.

Three pixel depths are handled. 8-bit pixels index a 256-entry palette that is written through the same register port. 16-bit pixels are RGB565 and are widened to 8 bits per channel. 32-bit pixels pass their low 24 bits through. Lines are packed back to back, so the pixel address rises by the pixel size for every pixel across the whole frame. When a frame ends the engine starts the next frame for as long as it stays enabled. The reserved format code halts scanout and raises a sticky error.

Top module: `crt_scanout`

## Requirements
- R1: After reset the control register reads 0x00010000, the base and both total registers read 0, and mem_req_o, pix_valid_o and fmt_err_o are low.
- R2: Registers sit at byte offsets 0x000 (control), 0x004 (base), 0x008 (horizontal total) and 0x00C (vertical total). A write keeps only value & 0x0003FFFF for control, value & 0x8FFFFFF0 for base and value & 0x0FFF0FFF for either total. The stored value reads back on reg_rdata_o in the same cycle.
- R3: The palette is 256 words of 32 bits at offsets 0xC00 + 4*i. Each word reads back in full.
- R4: Scanout runs only while control bit 2 is set. While it is clear, no request and no pixel is issued. Clearing it mid-frame stops requests and pixels from the second clock edge after the write.
- R5: Control bits 1:0 pick the format: 0 gives 1 byte per pixel, 1 gives 2 and 2 gives 4. Active width is horizontal-total bits 11:0 plus one, and height is vertical-total bits 11:0 plus one. The upper halves of the totals are ignored. Pixel k of a frame is read from byte address base[27:0] + k*bytes, and mem_addr_o presents that address with bits 1:0 cleared.
- R6: In the 8-bit format the pixel is byte (address bits 1:0) of the little-endian 32-bit word. The output is bits 23:0 of the palette word it indexes.
- R7: In the 16-bit format the pixel is the half-word chosen by address bit 1, read as RGB565. Each channel is widened by copying its top bits into the vacated low bits.
- R8: In the 32-bit format the output is bits 23:0 of the fetched word.
- R9: With the enable bit set and format code 3, fmt_err_o rises and no request or pixel is issued. The flag persists until the control register is written again, and writes to other registers leave it set.
- R10: frame_start_o pulses exactly once after a frame is launched and before that frame's first pixel. line_end_o is high together with the valid strobe of the last pixel of each line, and at no other time.
- R11: Once mem_req_o is raised, it stays high with mem_addr_o unchanged until mem_ready_i is seen high, unless scanout is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | ADDR_W | Word-aligned byte address of the request |
| mem_ready_i | input | 1 | Memory accepts request; data valid this cycle |
| mem_rdata_i | input | 32 | Memory read data |
| frame_start_o | output | 1 | Pulse before the first pixel of a frame |
| pix_valid_o | output | 1 | Pixel strobe |
| pix_rgb_o | output | 24 | Pixel colour, R in bits 23:16 |
| line_end_o | output | 1 | Marks the last pixel of a line |
| fmt_err_o | output | 1 | Sticky invalid-format flag |

## Verification
A wrong walker address or a stale lane select shows up at pix_rgb_o on the very pixel it affects, because every fetched word comes from an address-derived pattern. A bad palette index, lane choice or channel widening gives a wrong colour on the next strobe. A miscounted line or frame end appears as a misplaced line_end_o or a missing frame_start_o within one line of the fault. Random stalls on mem_ready_i expose a request that drops or changes its address on the following cycle.

// File: rtl/crt_scan_pkg.sv
package crt_scan_pkg;
  localparam logic [11:0] OFS_CTRL = 12'h000;
  localparam logic [11:0] OFS_BASE = 12'h004;
  localparam logic [11:0] OFS_HTOT = 12'h008;
  localparam logic [11:0] OFS_VTOT = 12'h00C;

  localparam logic [31:0] CTRL_MASK = 32'h0003_FFFF;
  localparam logic [31:0] CTRL_RST  = 32'h0001_0000;
  localparam logic [31:0] TOT_MASK  = 32'h0FFF_0FFF;
  localparam logic [31:0] BASE_MASK = 32'h8FFF_FFF0;

  localparam int CTRL_EN_BIT = 2;

  typedef enum logic [1:0] {
    FMT_8   = 2'd0,
    FMT_16  = 2'd1,
    FMT_32  = 2'd2,
    FMT_BAD = 2'd3
  } pix_fmt_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_REQ,
    ST_EMIT,
    ST_ERR
  } scan_st_e;
endpackage

// File: rtl/crt_regs.sv
module crt_regs
  import crt_scan_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int DIM_W  = 12,
  parameter int PAL_N  = 256
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [11:0]               addr_i,
  input  logic [31:0]               wdata_i,
  output logic [31:0]               rdata_o,
  output logic                      ctrl_wr_o,
  output logic                      en_o,
  output pix_fmt_e                  fmt_o,
  output logic [DIM_W-1:0]          width_m1_o,
  output logic [DIM_W-1:0]          height_m1_o,
  output logic [ADDR_W-1:0]         base_o,
  input  logic [$clog2(PAL_N)-1:0]  pal_idx_i,
  output logic [23:0]               pal_data_o
);
  localparam int PAL_AW = $clog2(PAL_N);

  logic [31:0] ctrl_q, base_q, htot_q, vtot_q;
  logic [31:0] pal_q [PAL_N];
  logic        pal_hit;

  assign pal_hit   = (addr_i[11:10] == 2'b11) && (addr_i[1:0] == 2'b00);
  assign ctrl_wr_o = we_i && (addr_i == OFS_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
      base_q <= '0;
      htot_q <= '0;
      vtot_q <= '0;
    end else if (we_i) begin
      case (addr_i)
        OFS_CTRL: ctrl_q <= wdata_i & CTRL_MASK;
        OFS_BASE: base_q <= wdata_i & BASE_MASK;
        OFS_HTOT: htot_q <= wdata_i & TOT_MASK;
        OFS_VTOT: vtot_q <= wdata_i & TOT_MASK;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (we_i && pal_hit) pal_q[addr_i[2 +: PAL_AW]] <= wdata_i;
  end

  always_comb begin
    rdata_o = '0;
    if (pal_hit) begin
      rdata_o = pal_q[addr_i[2 +: PAL_AW]];
    end else begin
      case (addr_i)
        OFS_CTRL: rdata_o = ctrl_q;
        OFS_BASE: rdata_o = base_q;
        OFS_HTOT: rdata_o = htot_q;
        OFS_VTOT: rdata_o = vtot_q;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign en_o        = ctrl_q[CTRL_EN_BIT];
  assign fmt_o       = pix_fmt_e'(ctrl_q[1:0]);
  assign width_m1_o  = htot_q[DIM_W-1:0];
  assign height_m1_o = vtot_q[DIM_W-1:0];
  assign base_o      = base_q[ADDR_W-1:0];
  assign pal_data_o  = pal_q[pal_idx_i][23:0];
endmodule

// File: rtl/crt_fetch.sv
module crt_fetch
  import crt_scan_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int DIM_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  pix_fmt_e          fmt_i,
  input  logic              ctrl_wr_i,
  input  logic [DIM_W-1:0]  width_m1_i,
  input  logic [DIM_W-1:0]  height_m1_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ready_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              frame_start_o,
  output logic              pix_stb_o,
  output logic              line_end_o,
  output logic              fmt_err_o,
  output pix_fmt_e          fmt_q_o,
  output logic [31:0]       word_o,
  output logic [1:0]        lane_o
);
  scan_st_e          st_q;
  pix_fmt_e          fmt_q;
  logic              err_q;
  logic [ADDR_W-1:0] addr_q, step;
  logic [DIM_W-1:0]  x_q, y_q, w_q, h_q;
  logic [31:0]       word_q;
  logic [1:0]        lane_q;
  logic              last_x;

  always_comb begin
    case (fmt_q)
      FMT_16:  step = ADDR_W'(2);
      FMT_32:  step = ADDR_W'(4);
      default: step = ADDR_W'(1);
    endcase
  end

  assign last_x = (x_q == w_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      fmt_q  <= FMT_8;
      err_q  <= 1'b0;
      addr_q <= '0;
      x_q    <= '0;
      y_q    <= '0;
      w_q    <= '0;
      h_q    <= '0;
      word_q <= '0;
      lane_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (en_i) begin
          if (fmt_i == FMT_BAD) begin
            err_q <= 1'b1;
            st_q  <= ST_ERR;
          end else begin
            fmt_q  <= fmt_i;
            w_q    <= width_m1_i;
            h_q    <= height_m1_i;
            addr_q <= base_i;
            x_q    <= '0;
            y_q    <= '0;
            st_q   <= ST_START;
          end
        end
        ST_START: st_q <= en_i ? ST_REQ : ST_IDLE;
        ST_REQ: begin
          if (!en_i) st_q <= ST_IDLE;
          else if (mem_ready_i) begin
            word_q <= mem_rdata_i;
            lane_q <= addr_q[1:0];
            st_q   <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          addr_q <= addr_q + step;
          if (!en_i) st_q <= ST_IDLE;
          else if (last_x) begin
            x_q <= '0;
            if (y_q == h_q) st_q <= ST_IDLE;
            else begin
              y_q  <= y_q + 1'b1;
              st_q <= ST_REQ;
            end
          end else begin
            x_q  <= x_q + 1'b1;
            st_q <= ST_REQ;
          end
        end
        ST_ERR: if (ctrl_wr_i) begin
          err_q <= 1'b0;
          st_q  <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o     = (st_q == ST_REQ);
  assign mem_addr_o    = {addr_q[ADDR_W-1:2], 2'b00};
  assign frame_start_o = (st_q == ST_START);
  assign pix_stb_o     = (st_q == ST_EMIT);
  assign line_end_o    = (st_q == ST_EMIT) && last_x;
  assign fmt_err_o     = err_q;
  assign fmt_q_o       = fmt_q;
  assign word_o        = word_q;
  assign lane_o        = lane_q;

  // R11
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i && en_i |=> mem_req_o && $stable(mem_addr_o));
  // R9
  no_out_on_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fmt_err_o |-> !pix_stb_o && !mem_req_o);
  // R9
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fmt_err_o && !ctrl_wr_i |=> fmt_err_o);
  // R10
  line_end_pix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_end_o |-> pix_stb_o);
  // R10
  start_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> !pix_stb_o);
endmodule

// File: rtl/crt_pixel.sv
module crt_pixel
  import crt_scan_pkg::*;
#(
  parameter int PAL_N = 256
) (
  input  pix_fmt_e                  fmt_i,
  input  logic [31:0]               word_i,
  input  logic [1:0]                lane_i,
  output logic [$clog2(PAL_N)-1:0]  pal_idx_o,
  input  logic [23:0]               pal_data_i,
  output logic [23:0]               rgb_o
);
  localparam int PAL_AW = $clog2(PAL_N);

  logic [31:0] shifted;
  logic [15:0] half;

  assign shifted   = word_i >> {lane_i, 3'b000};
  assign half      = lane_i[1] ? word_i[31:16] : word_i[15:0];
  assign pal_idx_o = shifted[PAL_AW-1:0];

  always_comb begin
    case (fmt_i)
      FMT_8:   rgb_o = pal_data_i;
      FMT_16:  rgb_o = {half[15:11], half[15:13],
                        half[10:5],  half[10:9],
                        half[4:0],   half[4:2]};
      default: rgb_o = word_i[23:0];
    endcase
  end
endmodule

// File: rtl/crt_scanout.sv
module crt_scanout
  import crt_scan_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int DIM_W  = 12,
  parameter int PAL_N  = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [11:0]       reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ready_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              frame_start_o,
  output logic              pix_valid_o,
  output logic [23:0]       pix_rgb_o,
  output logic              line_end_o,
  output logic              fmt_err_o
);
  localparam int PAL_AW = $clog2(PAL_N);

  logic              ctrl_wr, en;
  pix_fmt_e          fmt, fmt_q;
  logic [DIM_W-1:0]  width_m1, height_m1;
  logic [ADDR_W-1:0] base;
  logic [PAL_AW-1:0] pal_idx;
  logic [23:0]       pal_data;
  logic [31:0]       word;
  logic [1:0]        lane;

  crt_regs #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .PAL_N(PAL_N)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .rdata_o     (reg_rdata_o),
    .ctrl_wr_o   (ctrl_wr),
    .en_o        (en),
    .fmt_o       (fmt),
    .width_m1_o  (width_m1),
    .height_m1_o (height_m1),
    .base_o      (base),
    .pal_idx_i   (pal_idx),
    .pal_data_o  (pal_data)
  );

  crt_fetch #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_fetch (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (en),
    .fmt_i         (fmt),
    .ctrl_wr_i     (ctrl_wr),
    .width_m1_i    (width_m1),
    .height_m1_i   (height_m1),
    .base_i        (base),
    .mem_req_o     (mem_req_o),
    .mem_addr_o    (mem_addr_o),
    .mem_ready_i   (mem_ready_i),
    .mem_rdata_i   (mem_rdata_i),
    .frame_start_o (frame_start_o),
    .pix_stb_o     (pix_valid_o),
    .line_end_o    (line_end_o),
    .fmt_err_o     (fmt_err_o),
    .fmt_q_o       (fmt_q),
    .word_o        (word),
    .lane_o        (lane)
  );

  crt_pixel #(.PAL_N(PAL_N)) u_pixel (
    .fmt_i      (fmt_q),
    .word_i     (word),
    .lane_i     (lane),
    .pal_idx_o  (pal_idx),
    .pal_data_i (pal_data),
    .rgb_o      (pix_rgb_o)
  );
endmodule

// File: tb/crt_scanout_tb.sv
module crt_scanout_tb_top;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 28;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              reg_we_i = 1'b0;
  logic [11:0]       reg_addr_i = '0;
  logic [31:0]       reg_wdata_i = '0;
  logic [31:0]       reg_rdata_o;
  logic              mem_req_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic              mem_ready_i = 1'b0;
  logic [31:0]       mem_rdata_i;
  logic              frame_start_o, pix_valid_o, line_end_o, fmt_err_o;
  logic [23:0]       pix_rgb_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  crt_scanout dut_i (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  function automatic logic [31:0] mem_word(input logic [31:0] wa);
    return (wa * 32'h9E37_79B1) ^ 32'h5AC3_3C5A;
  endfunction

  function automatic logic [31:0] pal_val(input int i);
    return (32'(i) * 32'h0001_0307) ^ 32'hA55A_3CC3;
  endfunction

  function automatic logic [23:0] exp_rgb(input int fmt, input logic [31:0] a);
    logic [31:0] w;
    logic [15:0] h;
    logic [7:0]  b;
    w = mem_word({4'b0, a[27:2]});
    b = 8'(w >> (8 * a[1:0]));
    h = a[1] ? w[31:16] : w[15:0];
    if (fmt == 0) return pal_val(int'(b))[23:0];
    if (fmt == 1) return {h[15:11], h[15:13], h[10:5], h[10:9], h[4:0], h[4:2]};
    return w[23:0];
  endfunction

  assign mem_rdata_i = mem_word({6'b0, mem_addr_o[ADDR_W-1:2]});

  initial begin
    int c = 0;
    forever begin
      @(posedge clk_i);
      #2;
      c++;
      mem_ready_i = (c % 3 != 1) && (c % 7 != 3);
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic run_frame(input int fmt, input int w, input int h, input logic [31:0] base);
    int k = 0, fs = 0, tmo = 0, bpp;
    bit prev_stall = 0;
    logic [ADDR_W-1:0] prev_addr = '0;
    logic [31:0] a;
    string tag;
    bpp = (fmt == 0) ? 1 : (fmt == 1) ? 2 : 4;
    tag = (fmt == 0) ? "R6" : (fmt == 1) ? "R7" : "R8";
    wr(12'h008, 32'hF5A0_0000 | 32'(w - 1));
    wr(12'h00C, 32'h3C00_0000 | 32'(h - 1));
    wr(12'h004, base);
    wr(12'h000, 32'h4 | 32'(fmt));
    while (k < w * h && tmo < 20000) begin
      @(negedge clk_i);
      tmo++;
      // R11: stalled request must persist with the same address
      if (prev_stall) chk(mem_req_o && mem_addr_o == prev_addr, "R11 hold", 32'(mem_addr_o), 32'(prev_addr));
      prev_stall = mem_req_o && !mem_ready_i;
      prev_addr = mem_addr_o;
      if (frame_start_o) fs++;
      if (pix_valid_o) begin
        a = (base & 32'h0FFF_FFF0) + 32'(k * bpp);
        chk(fs == 1, "R10 frame_start", 32'(fs), 32'd1);
        chk(pix_rgb_o == exp_rgb(fmt, a), {tag, " R5 pixel"}, 32'(pix_rgb_o), 32'(exp_rgb(fmt, a)));
        chk(line_end_o == ((k % w) == w - 1), "R10 line_end", 32'(line_end_o), 32'((k % w) == w - 1));
        k++;
      end
    end
    chk(k == w * h, "R5 pixel count", 32'(k), 32'(w * h));
    wr(12'h000, 32'h0);
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int seen;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    rd(12'h000, d); chk(d == 32'h0001_0000, "R1 ctrl", d, 32'h0001_0000);
    rd(12'h004, d); chk(d == 0, "R1 base", d, 0);
    rd(12'h008, d); chk(d == 0, "R1 htot", d, 0);
    rd(12'h00C, d); chk(d == 0, "R1 vtot", d, 0);
    chk(!mem_req_o && !pix_valid_o && !fmt_err_o, "R1 outputs",
        {29'b0, mem_req_o, pix_valid_o, fmt_err_o}, 0);

    // R2 masking
    wr(12'h004, 32'hFFFF_FFFF); rd(12'h004, d); chk(d == 32'h8FFF_FFF0, "R2 base", d, 32'h8FFF_FFF0);
    wr(12'h008, 32'hFFFF_FFFF); rd(12'h008, d); chk(d == 32'h0FFF_0FFF, "R2 htot", d, 32'h0FFF_0FFF);
    wr(12'h00C, 32'hFFFF_FFFF); rd(12'h00C, d); chk(d == 32'h0FFF_0FFF, "R2 vtot", d, 32'h0FFF_0FFF);
    wr(12'h000, 32'hFFFF_FFFB); rd(12'h000, d); chk(d == 32'h0003_FFFB, "R2 ctrl", d, 32'h0003_FFFB);

    // R4 disabled: no activity
    wr(12'h000, 32'h1);
    seen = 0;
    repeat (20) begin @(negedge clk_i); if (mem_req_o || pix_valid_o) seen++; end
    chk(seen == 0, "R4 idle when disabled", 32'(seen), 0);

    // R3 palette
    for (int i = 0; i < 256; i++) wr(12'hC00 + 12'(4 * i), pal_val(i));
    foreach (d[j]) if (j < 4) begin
      int idx = (j == 0) ? 0 : (j == 1) ? 1 : (j == 2) ? 127 : 255;
      logic [31:0] r;
      rd(12'hC00 + 12'(4 * idx), r);
      chk(r == pal_val(idx), "R3 palette", r, pal_val(idx));
    end

    // R5..R8, R10, R11 frames
    run_frame(0, 4, 3, 32'h0000_0100);
    run_frame(0, 17, 2, 32'h0000_0453);
    run_frame(1, 5, 2, 32'h0000_2340);
    run_frame(1, 1, 1, 32'h0000_0010);
    run_frame(2, 3, 3, 32'h8000_1000);
    run_frame(0, 1, 1, 32'h0012_3450);
    run_frame(2, 2, 4, 32'h0FFF_FF00);

    // R9 invalid format
    wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h000, d); chk(d == 32'h0003_FFFF, "R2 ctrl all ones", d, 32'h0003_FFFF);
    repeat (2) @(negedge clk_i);
    chk(fmt_err_o, "R9 error set", 32'(fmt_err_o), 1);
    seen = 0;
    repeat (30) begin @(negedge clk_i); if (mem_req_o || pix_valid_o) seen++; end
    chk(seen == 0, "R9 no output", 32'(seen), 0);
    wr(12'h008, 32'h0000_0003);
    @(negedge clk_i);
    chk(fmt_err_o, "R9 sticky after other write", 32'(fmt_err_o), 1);
    wr(12'h000, 32'h0000_0001);
    repeat (2) @(negedge clk_i);
    chk(!fmt_err_o, "R9 cleared by control write", 32'(fmt_err_o), 0);

    // R4 abort mid-frame
    wr(12'h008, 32'd15); wr(12'h00C, 32'd3); wr(12'h004, 32'h400);
    wr(12'h000, 32'h6);
    seen = 0;
    while (seen < 3) begin @(negedge clk_i); if (pix_valid_o) seen++; end
    wr(12'h000, 32'h2);
    seen = 0;
    repeat (20) begin @(negedge clk_i); if (mem_req_o || pix_valid_o) seen++; end
    chk(seen == 0, "R4 abort stops scanout", 32'(seen), 0);

    finish_run();
  end
endmodule